// File: doc/BRIEF.md
# Line Test Pattern Transmit Generator

This block supplies the transmit bit stream of one T1/E1 line channel when the channel is placed in a test mode. A 2-bit pattern select picks the stream: user data passed through, a steady run of ones, a steady run of zeros, or a pseudo-random sequence. The two clocks that can time the stream are modelled as two clock-enable inputs. One is the line transmit clock. The other is the master clock. A clock-source bit chooses between them. That bit also changes the meaning of the normal select code: with the line clock selected, that code passes user data; with the master clock selected, it sends zeros.

The pseudo-random generator follows the line mode. In E1 mode it runs a plain 2^15-1 sequence. In T1 mode it runs a 2^20-1 quasi-random sequence in which no run of zeros exceeds 14. The most significant register bit goes out first. The sequence can be sent inverted. Whenever the generator is entered from another mode, it reloads a non-zero seed, so the sequence restarts from a known point.

Each selected enable produces one output bit, registered, together with a one-cycle valid strobe.

Top module: `line_pattern_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `tx_bit` and `tx_bit_valid` are 0.
- R2: The step enable is `line_clk_en` when `use_master_clk` is 0, and `master_clk_en` when it is 1. The non-selected enable has no effect. `tx_bit_valid` is high in exactly the cycles that follow a cycle with the step enable high.
- R3: With `pat_sel` = 00 and `use_master_clk` = 0, each step outputs the `tx_data_in` value sampled at that step.
- R4: With `pat_sel` = 00 and `use_master_clk` = 1, each step outputs 0.
- R5: With `pat_sel` = 01, each step outputs 1.
- R6: `pat_sel` = 11 behaves exactly like 00, including the dependence on `use_master_clk`.
- R7: With `pat_sel` = 10 and `e1_mode` = 1, the output follows a 15-bit register r. It is loaded with all ones on entry. Each step outputs r[14] and then shifts r left, inserting r[14] XOR r[13] at bit 0 (x^15+x^14+1). The sequence repeats every 32767 steps.
- R8: With `pat_sel` = 10 and `e1_mode` = 0, the generator uses a 20-bit register r. It is loaded with all ones on entry. Each step outputs r[19] OR (r[18:5] all zero) and then shifts r left, inserting r[19] XOR r[16] (x^20+x^17+1). No more than 14 consecutive zeros are sent.
- R9: `invert_prbs` = 1 inverts the pseudo-random output and has no effect in the other modes.
- R10: The generator is reseeded when `pat_sel` becomes 10 from another code, and when `e1_mode` changes while `pat_sel` is 10.
- R11: In cycles without a step, the generator does not advance and `tx_bit` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| line_clk_en | input | 1 | Line transmit clock enable |
| master_clk_en | input | 1 | Master clock enable |
| pat_sel | input | 2 | Pattern select: 00 normal, 01 ones, 10 pseudo-random, 11 as 00 |
| use_master_clk | input | 1 | 1 times the patterns from the master clock enable |
| e1_mode | input | 1 | 1 selects E1 (2^15-1), 0 selects T1 (quasi-random 2^20-1) |
| invert_prbs | input | 1 | Invert the pseudo-random output |
| tx_data_in | input | 1 | User transmit data |
| tx_bit | output | 1 | Transmit bit |
| tx_bit_valid | output | 1 | One-cycle strobe, high when a new `tx_bit` is presented |

## Verification
The bench builds the block with its default parameters: a 20-bit long register with its tap at 17, a 15-bit short register with its tap at 14, and a zero limit of 14. With these values one full E1 period of 32767 steps fits in the run, so the bench checks both the wrap back to the seed and every bit in between. About 60000 steps of the T1 sequence are compared bit by bit, which covers many zero-forced stretches and the bound on zero runs. Short vector tables cover each select code against both clock sources.

// File: rtl/pattgen_pkg.sv
package pattgen_pkg;

    typedef enum logic [1:0] {
        SEL_NORMAL = 2'b00,
        SEL_ONES   = 2'b01,
        SEL_PRBS   = 2'b10,
        SEL_RSVD   = 2'b11
    } pat_sel_e;

    typedef enum logic [1:0] {
        SRC_USER = 2'b00,
        SRC_ZERO = 2'b01,
        SRC_ONE  = 2'b10,
        SRC_GEN  = 2'b11
    } bit_src_e;

    typedef struct packed {
        logic valid;
        logic data;
    } tx_beat_t;

    // Maps the select code and clock-source bit to the bit source.
    function automatic bit_src_e decode_src(logic [1:0] sel, logic master);
        bit_src_e s;
        case (pat_sel_e'(sel))
            SEL_ONES: s = SRC_ONE;
            SEL_PRBS: s = SRC_GEN;
            default:  s = master ? SRC_ZERO : SRC_USER;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pattgen_decode.sv
module pattgen_decode
    import pattgen_pkg::*;
(
    input  logic       line_en,
    input  logic       master_en,
    input  logic       use_master,
    input  logic [1:0] sel,
    output logic       step,
    output bit_src_e   src,
    output logic       gen_active
);
    always_comb begin
        step       = use_master ? master_en : line_en;
        src        = decode_src(sel, use_master);
        gen_active = (src == SRC_GEN);
    end
endmodule

// File: rtl/pattgen_prbs.sv
module pattgen_prbs #(
    parameter int unsigned LONG_LEN   = 20,
    parameter int unsigned LONG_TAP   = 17,
    parameter int unsigned SHORT_LEN  = 15,
    parameter int unsigned SHORT_TAP  = 14,
    parameter int unsigned ZERO_LIMIT = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic short_mode,
    input  logic step,
    output logic gen_bit
);
    localparam int unsigned GW = LONG_LEN;
    localparam logic [GW-1:0] SEED = '1;

    logic [GW-1:0] state_q;
    logic [GW-1:0] cur;
    logic [GW-1:0] nxt_long;
    logic [GW-1:0] nxt_short;
    logic          active_q;
    logic          short_q;
    logic          entry;
    logic          fb_long;
    logic          fb_short;
    logic          raw_long;
    logic          bit_long;
    logic          bit_short;

    always_comb begin
        entry     = active && (!active_q || (short_q != short_mode));
        cur       = entry ? SEED : state_q;
        fb_long   = cur[LONG_LEN-1] ^ cur[LONG_TAP-1];
        fb_short  = cur[SHORT_LEN-1] ^ cur[SHORT_TAP-1];
        nxt_long  = {cur[GW-2:0], fb_long};
        nxt_short = GW'({cur[SHORT_LEN-2:0], fb_short});
        raw_long  = cur[LONG_LEN-1];
        bit_short = cur[SHORT_LEN-1];
    end

    generate
        if (ZERO_LIMIT > 0) begin : g_zero_force
            always_comb bit_long = raw_long | (cur[LONG_LEN-2 -: ZERO_LIMIT] == '0);
        end else begin : g_plain
            always_comb bit_long = raw_long;
        end
    endgenerate

    assign gen_bit = short_mode ? bit_short : bit_long;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEED;
            active_q <= 1'b0;
            short_q  <= 1'b0;
        end else begin
            active_q <= active;
            short_q  <= short_mode;
            if (active) begin
                if (step) state_q <= short_mode ? nxt_short : nxt_long;
                else      state_q <= cur;
            end
        end
    end
endmodule

// File: rtl/pattgen_outreg.sv
module pattgen_outreg
    import pattgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     step,
    input  bit_src_e src,
    input  logic     user_bit,
    input  logic     gen_bit,
    input  logic     invert,
    output tx_beat_t beat
);
    logic chosen;

    always_comb begin
        unique case (src)
            SRC_USER: chosen = user_bit;
            SRC_ZERO: chosen = 1'b0;
            SRC_ONE:  chosen = 1'b1;
            default:  chosen = gen_bit ^ invert;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.valid <= step;
            if (step) beat.data <= chosen;
        end
    end
endmodule

// File: rtl/line_pattern_gen.sv
module line_pattern_gen
    import pattgen_pkg::*;
#(
    parameter int unsigned LONG_LEN   = 20,
    parameter int unsigned LONG_TAP   = 17,
    parameter int unsigned SHORT_LEN  = 15,
    parameter int unsigned SHORT_TAP  = 14,
    parameter int unsigned ZERO_LIMIT = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_clk_en,
    input  logic       master_clk_en,
    input  logic [1:0] pat_sel,
    input  logic       use_master_clk,
    input  logic       e1_mode,
    input  logic       invert_prbs,
    input  logic       tx_data_in,
    output logic       tx_bit,
    output logic       tx_bit_valid
);
    logic     step;
    logic     gen_active;
    logic     gen_bit;
    bit_src_e src;
    tx_beat_t beat;

    pattgen_decode u_decode (
        .line_en    (line_clk_en),
        .master_en  (master_clk_en),
        .use_master (use_master_clk),
        .sel        (pat_sel),
        .step       (step),
        .src        (src),
        .gen_active (gen_active)
    );

    pattgen_prbs #(
        .LONG_LEN   (LONG_LEN),
        .LONG_TAP   (LONG_TAP),
        .SHORT_LEN  (SHORT_LEN),
        .SHORT_TAP  (SHORT_TAP),
        .ZERO_LIMIT (ZERO_LIMIT)
    ) u_prbs (
        .clk        (clk),
        .rst        (rst),
        .active     (gen_active),
        .short_mode (e1_mode),
        .step       (step),
        .gen_bit    (gen_bit)
    );

    pattgen_outreg u_out (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .src      (src),
        .user_bit (tx_data_in),
        .gen_bit  (gen_bit),
        .invert   (invert_prbs),
        .beat     (beat)
    );

    assign tx_bit       = beat.data;
    assign tx_bit_valid = beat.valid;
endmodule

// File: rtl/line_pattern_gen_chk.sv
module line_pattern_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       line_clk_en,
    input logic       master_clk_en,
    input logic [1:0] pat_sel,
    input logic       use_master_clk,
    input logic       e1_mode,
    input logic       invert_prbs,
    input logic       tx_data_in,
    input logic       tx_bit,
    input logic       tx_bit_valid
);
    logic       en_sel;
    logic       normal_code;
    logic       t1_gen_q;
    logic [7:0] zero_run;

    assign en_sel      = use_master_clk ? master_clk_en : line_clk_en;
    assign normal_code = (pat_sel[1] == pat_sel[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            t1_gen_q <= 1'b0;
            zero_run <= '0;
        end else begin
            t1_gen_q <= en_sel && (pat_sel == 2'b10) && !e1_mode && !invert_prbs;
            if (tx_bit_valid) begin
                if (t1_gen_q && !tx_bit && zero_run != 8'hFF) zero_run <= zero_run + 8'd1;
                else zero_run <= '0;
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!tx_bit && !tx_bit_valid)); // R1

    AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
        en_sel |=> tx_bit_valid); // R2

    AST_NO_STEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !en_sel |=> (!tx_bit_valid && $stable(tx_bit))); // R11

    AST_USER_PASS: assert property (@(posedge clk) disable iff (rst)
        (normal_code && !use_master_clk && line_clk_en) |=> (tx_bit == $past(tx_data_in))); // R3

    AST_MASTER_ZEROS: assert property (@(posedge clk) disable iff (rst)
        (normal_code && use_master_clk && master_clk_en) |=> !tx_bit); // R4

    AST_ONES_SENT: assert property (@(posedge clk) disable iff (rst)
        ((pat_sel == 2'b01) && en_sel) |=> tx_bit); // R5

    AST_ZERO_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        zero_run <= 8'd14); // R8
endmodule

bind line_pattern_gen line_pattern_gen_chk u_chk (.*);

// File: tb/line_pattern_gen_test.sv
module line_pattern_gen_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 190000;

    typedef struct packed {
        logic       src;
        logic [1:0] sel;
        logic       len;
        logic       men;
        logic       inv;
        logic       ud;
        logic       ev;
        logic       eb;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3},  // R3 pass 1
        '{1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 pass 0
        '{1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 master ignored
        '{1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3},  // R3
        '{1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 line ignored
        '{1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 zeros
        '{1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 ones
        '{1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},  // R3
        '{1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 master
        '{1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 as pass
        '{1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 as pass
        '{1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 as zeros
        '{1'b0, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd9},  // R9 ones not inverted
        '{1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd9},  // R9 user not inverted
        '{1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2}   // R2 no enable
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_clk_en = 1'b0;
    logic       master_clk_en = 1'b0;
    logic [1:0] pat_sel = 2'b00;
    logic       use_master_clk = 1'b0;
    logic       e1_mode = 1'b0;
    logic       invert_prbs = 1'b0;
    logic       tx_data_in = 1'b0;
    logic       tx_bit;
    logic       tx_bit_valid;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    logic [19:0] m;

    line_pattern_gen uut (
        .clk            (clk),
        .rst            (rst),
        .line_clk_en    (line_clk_en),
        .master_clk_en  (master_clk_en),
        .pat_sel        (pat_sel),
        .use_master_clk (use_master_clk),
        .e1_mode        (e1_mode),
        .invert_prbs    (invert_prbs),
        .tx_data_in     (tx_data_in),
        .tx_bit         (tx_bit),
        .tx_bit_valid   (tx_bit_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Reference sequence, built from the R7/R8 definitions.
    function automatic logic model_out(input logic [19:0] r, input logic e1);
        if (e1) return r[14];
        return r[19] | (r[18:5] == 14'd0);
    endfunction

    function automatic logic [19:0] model_adv(input logic [19:0] r, input logic e1);
        if (e1) return {5'd0, r[13:0], r[14] ^ r[13]};
        return {r[18:0], r[19] ^ r[16]};
    endfunction

    task automatic prbs_run(input int n, input string req, output int maxrun);
        int errs = 0;
        int vbad = 0;
        int run  = 0;
        logic e;
        maxrun = 0;
        line_clk_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            e = model_out(m, e1_mode) ^ invert_prbs;
            m = model_adv(m, e1_mode);
            tick();
            if (tx_bit !== e) errs++;
            if (tx_bit_valid !== 1'b1) vbad++;
            if (tx_bit) run = 0;
            else begin
                run++;
                if (run > maxrun) maxrun = run;
            end
        end
        line_clk_en = 1'b0;
        check({req, " sequence mismatches"}, errs, 0);
        check("R2 valid during run", vbad, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int mr;
        int ones;
        logic held;
        @(negedge clk);
        line_clk_en   = 1'b1;
        master_clk_en = 1'b1;
        tx_data_in    = 1'b1;
        tick(); tick();
        check("R1 reset valid", int'(tx_bit_valid), 0);
        check("R1 reset bit", int'(tx_bit), 0);
        rst = 1'b0;
        line_clk_en   = 1'b0;
        master_clk_en = 1'b0;
        tick();
        check("R1 first cycle after reset", int'(tx_bit_valid), 0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            use_master_clk = VECS[i].src;
            pat_sel        = VECS[i].sel;
            line_clk_en    = VECS[i].len;
            master_clk_en  = VECS[i].men;
            invert_prbs    = VECS[i].inv;
            tx_data_in     = VECS[i].ud;
            tick();
            check($sformatf("R%0d vec %0d valid", VECS[i].req, i), int'(tx_bit_valid), int'(VECS[i].ev));
            if (VECS[i].ev)
                check($sformatf("R%0d vec %0d bit", VECS[i].req, i), int'(tx_bit), int'(VECS[i].eb));
        end
        line_clk_en = 1'b0; master_clk_en = 1'b0; invert_prbs = 1'b0;
        use_master_clk = 1'b0;

        // R7: E1 sequence, full period, then wrap to seed
        e1_mode = 1'b1;
        pat_sel = 2'b10;
        m = 20'hFFFFF;
        prbs_run(32767, "R7", mr);
        check("R7 model back at seed", int'(m[14:0]), 32'h7FFF);
        m = 20'hFFFFF;
        ones = 0;
        line_clk_en = 1'b1;
        for (int i = 0; i < 15; i++) begin
            tick();
            if (tx_bit) ones++;
        end
        line_clk_en = 1'b0;
        m = model_adv(m, 1'b1);
        for (int i = 1; i < 15; i++) m = model_adv(m, 1'b1);
        check("R7 period wrap ones", ones, 15);

        // R11: no step holds output and generator
        held = tx_bit;
        for (int i = 0; i < 3; i++) begin
            master_clk_en = 1'b1;
            tick();
        end
        master_clk_en = 1'b0;
        check("R11 bit held", int'(tx_bit), int'(held));
        check("R11 no valid", int'(tx_bit_valid), 0);
        prbs_run(40, "R11 resume", mr);

        // R10: line mode change reseeds; R8 T1 sequence
        e1_mode = 1'b0;
        m = 20'hFFFFF;
        prbs_run(60000, "R8", mr);
        check("R8 zero run within 14", int'(mr <= 14), 1);

        // R10: leave and re-enter the generator
        pat_sel = 2'b01;
        line_clk_en = 1'b1;
        tick();
        line_clk_en = 1'b0;
        pat_sel = 2'b10;
        m = 20'hFFFFF;
        prbs_run(200, "R10 re-entry", mr);

        // R9: inverted E1 sequence, starts at zeros
        e1_mode = 1'b1;
        invert_prbs = 1'b1;
        m = 20'hFFFFF;
        line_clk_en = 1'b1;
        tick();
        line_clk_en = 1'b0;
        check("R9 inverted seed bit", int'(tx_bit), 0);
        m = model_adv(m, 1'b1);
        prbs_run(300, "R9", mr);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule